// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the conversion phase of a serial-access analog-to-digital converter. It waits in idle until the serial port signals, with a one-cycle start pulse, that the last falling clock edge of a transfer has passed. It then counts a configurable oscillator start-up delay and spends one full oscillator period settling. After that it resolves one result bit per oscillator period, most significant bit first, against a single-bit comparator input. On a final half period it latches the finished code into the output data register.

The sequencer runs on a tick clock at twice the internal oscillator rate, so one oscillator period is two ticks. The conversion proper is 13.5 periods, which is 27 ticks. A status pin reports progress in one of two modes, which is captured at each start. In end-of-conversion mode the pin is low while a conversion runs and high otherwise. In interrupt mode the pin goes low when a result is latched and stays low until the next chip-select falling edge, which the serial side reports as a one-tick pulse.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset the status pin is high, the result strobe is low, and both the trial code and the result register read zero.
- R2: In end-of-conversion mode (mode input 0 at start), the status pin is low at the first tick after the edge that accepts the start pulse. This latency is always the same.
- R3: The result strobe is high for exactly one tick. With T = 2*START_DLY + 27, it is seen T+1 ticks after the start pulse is driven, counting the accepting edge as the first tick. It is never high at any other time.
- R4: The trial code is zero during the start-up delay and the settle period. It then shows 0x800 for two ticks, and after that it shows the decided MSB with bit 10 set. Each trial is held for two ticks.
- R5: Trial bits are kept when the comparator input is 1 and cleared when it is 0. The latched result equals the code found by this MSB-first binary search.
- R6: In end-of-conversion mode the status pin returns high in the same tick in which the strobe is high and the new result is visible.
- R7: In interrupt mode (mode input 1 at start) the status pin stays high during the conversion and goes low with the strobe. It then stays low until a chip-select fall pulse, and is high one tick after that pulse.
- R8: A start pulse that arrives while a conversion is running is ignored. The strobe timing of the running conversion does not change.
- R9: A chip-select fall pulse has no effect on the status pin in end-of-conversion mode.
- R10: The mode input is captured when a start is accepted. Changing it during a conversion does not change the pin's behaviour for that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the oscillator rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | One-tick pulse marking the end of the serial transfer |
| cs_fall | input | 1 | One-tick pulse marking a chip-select falling edge |
| int_sel | input | 1 | Status pin mode: 0 end-of-conversion, 1 interrupt |
| cmp_hi | input | 1 | Comparator: 1 when the sampled input is at or above the trial code |
| trial_code | output | RES_BITS | Current successive-approximation trial code |
| result_data | output | RES_BITS | Output data register |
| result_stb | output | 1 | One-tick strobe when the result is latched |
| status_pin | output | 1 | End-of-conversion or interrupt indicator |

## Verification
A tick counter that is off by one moves the strobe and the rising edge of the end-of-conversion pin by a whole tick, and that shows up on the first conversion. A fault in the approximation register shows on the trial code within two ticks of the bit involved, and on the latched result at the end of the same conversion. A start that is wrongly accepted mid-conversion, or a mode that is not captured, shows as a misplaced strobe or pin edge in that same conversion. A pin that is released too early in interrupt mode is seen in the idle ticks before the chip-select pulse.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   // ticks per oscillator period (tick clock runs at twice the oscillator)
   localparam int TICKS_PER_OSC = 2;

   // total ticks from accepted start to result latch
   function automatic int conv_ticks(input int res_bits, input int start_dly);
      return TICKS_PER_OSC * start_dly + TICKS_PER_OSC + TICKS_PER_OSC * res_bits + 1;
   endfunction

   function automatic int width_for(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/conv_tick_timer.sv
module conv_tick_timer
   import sar_seq_pkg::*;
#(
   parameter int RES_BITS  = 12,
   parameter int START_DLY = 1,
   parameter int CNT_W     = width_for(conv_ticks(RES_BITS, START_DLY)),
   parameter int IDX_W     = width_for(RES_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   output logic             busy,
   output logic [CNT_W-1:0] tick_cnt,
   output logic             seed_fire,
   output logic             decide_fire,
   output logic [IDX_W-1:0] bit_idx,
   output logic             latch_fire
);
   localparam int TOTAL      = conv_ticks(RES_BITS, START_DLY);
   localparam int SETTLE_BEG = TICKS_PER_OSC * START_DLY;
   localparam int FIRST_DEC  = SETTLE_BEG + 3;
   localparam int LAST_DEC   = FIRST_DEC + TICKS_PER_OSC * (RES_BITS - 1);

   logic [CNT_W-1:0] rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         tick_cnt <= '0;
      end else if (start_ok) begin
         busy     <= 1'b1;
         tick_cnt <= '0;
      end else if (busy) begin
         if (latch_fire) begin
            busy     <= 1'b0;
            tick_cnt <= '0;
         end else begin
            tick_cnt <= tick_cnt + 1'b1;
         end
      end
   end

   always_comb begin
      rel         = tick_cnt - CNT_W'(FIRST_DEC);
      seed_fire   = busy && (tick_cnt == CNT_W'(SETTLE_BEG + 1));
      decide_fire = busy && (tick_cnt >= CNT_W'(FIRST_DEC)) &&
                    (tick_cnt <= CNT_W'(LAST_DEC)) && !rel[0];
      bit_idx     = IDX_W'(rel >> 1);
      latch_fire  = busy && (tick_cnt == CNT_W'(TOTAL - 1));
   end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int RES_BITS = 12,
   parameter int IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                seed,
   input  logic                decide,
   input  logic [IDX_W-1:0]    bit_idx,
   input  logic                cmp_hi,
   output logic [RES_BITS-1:0] trial
);
   for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
      localparam int POS = RES_BITS - 1 - i;   // decision index of this bit
      if (i == RES_BITS - 1) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   trial[i] <= 1'b0;
            else if (clear)                               trial[i] <= 1'b0;
            else if (seed)                                trial[i] <= 1'b1;
            else if (decide && bit_idx == IDX_W'(POS))    trial[i] <= cmp_hi;
         end
      end else begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   trial[i] <= 1'b0;
            else if (clear)                               trial[i] <= 1'b0;
            else if (decide && bit_idx == IDX_W'(POS))    trial[i] <= cmp_hi;
            else if (decide && bit_idx == IDX_W'(POS - 1)) trial[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/status_pin_drv.sv
module status_pin_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic start_ok,
   input  logic int_sel,
   input  logic latch_fire,
   input  logic cs_fall,
   output logic mode_q,
   output logic pin
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         pin    <= 1'b1;
      end else begin
         if (start_ok) mode_q <= int_sel;
         if (latch_fire)                pin <= ~mode_q;
         else if (start_ok && !int_sel) pin <= 1'b0;
         else if (cs_fall && mode_q)    pin <= 1'b1;
      end
   end
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
   import sar_seq_pkg::*;
#(
   parameter int RES_BITS  = 12,
   parameter int START_DLY = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_start,
   input  logic                cs_fall,
   input  logic                int_sel,
   input  logic                cmp_hi,
   output logic [RES_BITS-1:0] trial_code,
   output logic [RES_BITS-1:0] result_data,
   output logic                result_stb,
   output logic                status_pin
);
   localparam int CNT_W = width_for(conv_ticks(RES_BITS, START_DLY));
   localparam int IDX_W = width_for(RES_BITS);

   if (RES_BITS < 2 || RES_BITS > 16) begin : g_bad_res
      initial $error("RES_BITS out of range 2..16");
   end
   if (START_DLY < 0 || START_DLY > 64) begin : g_bad_dly
      initial $error("START_DLY out of range 0..64");
   end

   logic             busy;
   logic             start_ok;
   logic [CNT_W-1:0] tick_cnt;
   logic             seed_fire;
   logic             decide_fire;
   logic [IDX_W-1:0] bit_idx;
   logic             latch_fire;
   logic             mode_q;

   assign start_ok = conv_start && !busy;

   conv_tick_timer #(
      .RES_BITS (RES_BITS),
      .START_DLY(START_DLY),
      .CNT_W    (CNT_W),
      .IDX_W    (IDX_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ok   (start_ok),
      .busy       (busy),
      .tick_cnt   (tick_cnt),
      .seed_fire  (seed_fire),
      .decide_fire(decide_fire),
      .bit_idx    (bit_idx),
      .latch_fire (latch_fire)
   );

   sar_trial_reg #(
      .RES_BITS(RES_BITS),
      .IDX_W   (IDX_W)
   ) u_sar (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start_ok),
      .seed   (seed_fire),
      .decide (decide_fire),
      .bit_idx(bit_idx),
      .cmp_hi (cmp_hi),
      .trial  (trial_code)
   );

   status_pin_drv u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_ok  (start_ok),
      .int_sel   (int_sel),
      .latch_fire(latch_fire),
      .cs_fall   (cs_fall),
      .mode_q    (mode_q),
      .pin       (status_pin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_data <= '0;
         result_stb  <= 1'b0;
      end else begin
         result_stb <= latch_fire;
         if (latch_fire) result_data <= trial_code;
      end
   end
endmodule

// File: rtl/sar_conv_sequencer_chk.sv
module sar_conv_sequencer_chk #(
   parameter int RES_BITS = 12,
   parameter int CNT_W    = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                conv_start,
   input logic                cs_fall,
   input logic                int_sel,
   input logic                busy,
   input logic [CNT_W-1:0]    tick_cnt,
   input logic                latch_fire,
   input logic                mode_q,
   input logic                status_pin,
   input logic                result_stb,
   input logic [RES_BITS-1:0] result_data
);
   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      result_stb |=> !result_stb);

   p_eoc_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && !busy && !int_sel) |=> !status_pin);

   p_pin_at_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_stb |-> (status_pin == !mode_q));

   p_int_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !status_pin && !cs_fall && !(conv_start && !busy)) |=> !status_pin);

   p_tick_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !latch_fire) |=> (busy && tick_cnt == CNT_W'($past(tick_cnt) + 1'b1)));

   p_result_only_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_data) |-> result_stb);
endmodule

bind sar_conv_sequencer sar_conv_sequencer_chk #(
   .RES_BITS(RES_BITS),
   .CNT_W   (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .cs_fall    (cs_fall),
   .int_sel    (int_sel),
   .busy       (busy),
   .tick_cnt   (tick_cnt),
   .latch_fire (latch_fire),
   .mode_q     (mode_q),
   .status_pin (status_pin),
   .result_stb (result_stb),
   .result_data(result_data)
);

// File: tb/sar_conv_sequencer_tb.sv
module sar_conv_sequencer_tb;
   localparam int RES   = 12;
   localparam int DLY   = 1;
   localparam int TOT   = 2 * DLY + 2 * RES + 3;
   localparam int SETB  = 2 * DLY;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           conv_start = 1'b0;
   logic           cs_fall = 1'b0;
   logic           int_sel = 1'b0;
   logic           cmp_hi;
   logic [RES-1:0] trial_code;
   logic [RES-1:0] result_data;
   logic           result_stb;
   logic           status_pin;
   logic [RES-1:0] v_analog = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   assign cmp_hi = (v_analog >= trial_code);

   sar_conv_sequencer #(.RES_BITS(RES), .START_DLY(DLY)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .cs_fall    (cs_fall),
      .int_sel    (int_sel),
      .cmp_hi     (cmp_hi),
      .trial_code (trial_code),
      .result_data(result_data),
      .result_stb (result_stb),
      .status_pin (status_pin)
   );

   // binary search as the requirements define it
   function automatic logic [RES-1:0] exp_search(input logic [RES-1:0] v);
      logic [RES-1:0] t = '0;
      for (int b = RES - 1; b >= 0; b--) begin
         t[b] = 1'b1;
         if (!(v >= t)) t[b] = 1'b0;
      end
      return t;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_conv(input logic [RES-1:0] v, input bit im, input bit restart,
                          input bit cs_mid, input bit flip);
      logic [RES-1:0] ev = exp_search(v);
      v_analog   = v;
      int_sel    = im;
      conv_start = 1'b1;
      for (int n = 1; n <= TOT + 1; n++) begin
         @(negedge clk);
         // outputs after the n-th edge counting the accepting one
         chk(result_stb == (n == TOT + 1), "R3", int'(result_stb), int'(n == TOT + 1));
         if (!im)
            chk(status_pin == (n == TOT + 1), (n == 1) ? "R2" : (n == TOT + 1) ? "R6" : "R9/R10",
                int'(status_pin), int'(n == TOT + 1));
         else
            chk(status_pin == (n != TOT + 1), "R7/R10", int'(status_pin), int'(n != TOT + 1));
         if (n == SETB + 2) chk(trial_code == '0, "R4", int'(trial_code), 0);
         if (n == SETB + 3 || n == SETB + 4)
            chk(trial_code == 12'h800, "R4", int'(trial_code), 'h800);
         if (n == SETB + 5)
            chk(trial_code == {v[11], 1'b1, 10'b0}, "R4", int'(trial_code),
                int'({v[11], 1'b1, 10'b0}));
         if (n == TOT + 1) begin
            chk(result_data == ev, "R5", int'(result_data), int'(ev));
            chk(result_data == v, "R5", int'(result_data), int'(v));
         end
         // stimulus for the next edge
         conv_start = restart && (n == 10);
         if (flip && n == 7) int_sel = ~im;
         cs_fall = cs_mid && !im && (n == 12);
      end
      conv_start = 1'b0;
      cs_fall    = 1'b0;
      if (im) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(status_pin == 1'b0, "R7", int'(status_pin), 0);
            chk(result_stb == 1'b0, "R3", int'(result_stb), 0);
         end
         cs_fall = 1'b1;
         @(negedge clk);
         cs_fall = 1'b0;
         chk(status_pin == 1'b1, "R7", int'(status_pin), 1);
      end
      @(negedge clk);
      chk(result_stb == 1'b0, "R3", int'(result_stb), 0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(status_pin == 1'b1, "R1", int'(status_pin), 1);
      chk(result_stb == 1'b0, "R1", int'(result_stb), 0);
      chk(trial_code == '0, "R1", int'(trial_code), 0);
      chk(result_data == '0, "R1", int'(result_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      do_conv(12'h000, 1'b0, 1'b0, 1'b0, 1'b0);
      do_conv(12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0);
      do_conv(12'h800, 1'b1, 1'b0, 1'b0, 1'b0);
      do_conv(12'h7FF, 1'b1, 1'b0, 1'b0, 1'b0);
      do_conv(12'hA5A, 1'b0, 1'b1, 1'b0, 1'b0);   // R8 restart ignored
      do_conv(12'h3C3, 1'b0, 1'b0, 1'b1, 1'b0);   // R9 chip-select in EOC mode
      do_conv(12'h1F0, 1'b0, 1'b0, 1'b0, 1'b1);   // R10 mode flip mid-run
      do_conv(12'h0F1, 1'b1, 1'b1, 1'b0, 1'b1);   // R10 / R8 in interrupt mode

      for (int i = 0; i < 40; i++) begin
         logic [RES-1:0] rv = RES'($urandom);
         bit rm = 1'($urandom);
         bit rr = 1'($urandom);
         bit rc = 1'($urandom);
         bit rf = 1'($urandom);
         do_conv(rv, rm, rr, rc, rf);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule